// File: doc/BRIEF.md
# Flash Write Controller with Lock-Bits

This block is the command and write-control core of a byte-wide flash array that is split into 64-Kbyte blocks. The number of blocks is set by a parameter and may be 8, 16 or 32. A host writes one command per cycle over a small command port. The command selects an operation code and a target block. The block decides whether the operation may run and then sequences it through a write state machine. Each kind of operation holds the machine busy for a number of cycles set by its own parameter.

Two levels of lock protect the array. Each block has a lock-bit that refuses erase and program on that block. A single master lock-bit refuses every change to the lock-bits. An erase or a program can be suspended and then resumed. While an erase is suspended, a program may run on a different block. A ready/busy output and an 8-bit status word report activity, suspension and errors.

An active-low power-down input aborts all activity at once, returns the machine to idle and clears the status word. The lock-bits are kept through power-down. When power-down is released, commands are ignored until a wake delay has passed.

Top module: `flash_write_ctrl`

## Requirements
- R1: While `pwrDnN` is low, `readyOut` is 1, `status` reads 0x80 and every command is ignored. Pulling `pwrDnN` low in the middle of an operation aborts that operation. Status bit map: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 lock violation, bit 2 program suspended, bits 1:0 always 0.
- R2: After `pwrDnN` rises, commands sampled on the first WAKE_CYC rising clock edges are ignored. A command held on the next edge is accepted on that edge.
- R3: Erase (`cmdOp`=1) on an unlocked block drives `readyOut` and status bit 7 low for exactly ERASE_CYC cycles, starting in the cycle after the accepting edge. Both return high after that.
- R4: Program (`cmdOp`=2) on an unlocked block is busy for exactly PROG_CYC cycles.
- R5: The lock configurations are set block lock-bit (`cmdOp`=5), set master lock-bit (`cmdOp`=6) and clear all block lock-bits (`cmdOp`=7). Each is busy for LOCK_CYC cycles. Its effect on `lockBits` or `masterLock` appears only when it completes.
- R6: An erase or program aimed at a locked block is refused in the accepting cycle. `readyOut` stays high. Bit 3 is set, together with bit 5 for an erase or bit 4 for a program. `lockBits` does not change.
- R7: While `masterLock` is 1, all three lock configurations are refused: bits 4 and 3 are set, and `lockBits` and `masterLock` do not change. Erase and program on unlocked blocks still run.
- R8: Suspend (`cmdOp`=3) during an erase sets `readyOut` high and status bit 6. Resume (`cmdOp`=4) continues the erase. The busy cycles before and after the suspension add up to ERASE_CYC.
- R9: Suspend during a program sets `readyOut` high and status bit 2. After resume, the busy cycles add up to PROG_CYC.
- R10: During an erase suspension, a program to another unlocked block runs for PROG_CYC cycles and bit 6 stays set. A program to the block being erased is refused with bit 4 only.
- R11: Clear-status (`cmdOp`=8) clears bits 5, 4 and 3 and leaves bits 7, 6 and 2 unchanged.
- R12: The lock-bits and the master lock-bit keep their values through power-down.
- R13: While an operation is busy, every command other than suspend is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrDnN | input | 1 | Active-low reset / power-down, asynchronous assert |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 4 | Operation code |
| cmdBlock | input | log2(NUM_BLOCKS) | Target block |
| readyOut | output | 1 | 1 = ready or suspended, 0 = busy |
| status | output | 8 | Status word |
| lockBits | output | NUM_BLOCKS | Per-block lock-bits |
| masterLock | output | 1 | Master lock-bit |

## Verification
Most internal faults show up on `readyOut` within the busy window of the operation concerned:
- A busy counter that is off by one moves the rising edge of `readyOut` by a cycle.
- A suspend that loses or double-counts a cycle shows only when the resumed operation finishes.

Faults in lock gating and error handling show on `status` in the cycle right after the refused command. Faults in lock commitment show on `lockBits` at the end of the configuration, and again after a power-down, where retention is checked.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_ERASE      = 4'd1,
    OP_PROG       = 4'd2,
    OP_SUSPEND    = 4'd3,
    OP_RESUME     = 4'd4,
    OP_LOCK_BLK   = 4'd5,
    OP_LOCK_MST   = 4'd6,
    OP_UNLOCK_ALL = 4'd7,
    OP_CLR_STAT   = 4'd8
  } fwc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_PROG, ST_LOCK, ST_ESUSP, ST_ESPROG, ST_PSUSP
  } fwc_state_e;

  typedef enum logic [1:0] { LK_BLK, LK_MST, LK_CLR } fwc_lock_e;

  // control -> datapath strobes
  typedef struct packed {
    logic loadErase;
    logic decErase;
    logic loadWork;
    logic workIsProg;
    logic decWork;
    logic setBlk;
    logic setMst;
    logic clrLocks;
    logic errErase;
    logic errProg;
    logic errLock;
    logic clrErr;
  } fwc_strobe_t;

  // datapath -> control feedback
  typedef struct packed {
    logic eraseLast;
    logic workLast;
    logic wakeDone;
    logic blkLocked;
    logic sameAsErase;
    logic masterLock;
  } fwc_fb_t;

endpackage

// File: rtl/fwc_control.sv
module fwc_control
  import fwc_pkg::*;
(
  input  logic        clk,
  input  logic        pwrDnN,
  input  logic        cmdValid,
  input  logic [3:0]  cmdOp,
  input  fwc_fb_t     fb,
  output fwc_strobe_t strb,
  output logic        readyFlag,
  output logic        eraseSusp,
  output logic        progSusp
);

  fwc_state_e stateQ, stateNxt;
  fwc_lock_e  kindQ, kindNxt;
  fwc_op_e    op;
  logic       accept;

  always_ff @(posedge clk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      stateQ <= ST_IDLE;
      kindQ  <= LK_BLK;
    end else begin
      stateQ <= stateNxt;
      kindQ  <= kindNxt;
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = stateQ;
    kindNxt  = kindQ;
    op       = fwc_op_e'(cmdOp);
    accept   = cmdValid && fb.wakeDone;
    case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_ERASE: begin
              if (fb.blkLocked) begin
                strb.errErase = 1'b1;
                strb.errLock  = 1'b1;
              end else begin
                strb.loadErase = 1'b1;
                stateNxt       = ST_ERASE;
              end
            end
            OP_PROG: begin
              if (fb.blkLocked) begin
                strb.errProg = 1'b1;
                strb.errLock = 1'b1;
              end else begin
                strb.loadWork   = 1'b1;
                strb.workIsProg = 1'b1;
                stateNxt        = ST_PROG;
              end
            end
            OP_LOCK_BLK, OP_LOCK_MST, OP_UNLOCK_ALL: begin
              if (fb.masterLock) begin
                strb.errProg = 1'b1;
                strb.errLock = 1'b1;
              end else begin
                strb.loadWork = 1'b1;
                stateNxt      = ST_LOCK;
                kindNxt       = (op == OP_LOCK_BLK) ? LK_BLK :
                                (op == OP_LOCK_MST) ? LK_MST : LK_CLR;
              end
            end
            OP_CLR_STAT: strb.clrErr = 1'b1;
            default: ;
          endcase
        end
      end
      ST_ERASE: begin
        if (fb.eraseLast) stateNxt = ST_IDLE;
        else begin
          strb.decErase = 1'b1;
          if (accept && op == OP_SUSPEND) stateNxt = ST_ESUSP;
        end
      end
      ST_PROG: begin
        if (fb.workLast) stateNxt = ST_IDLE;
        else begin
          strb.decWork = 1'b1;
          if (accept && op == OP_SUSPEND) stateNxt = ST_PSUSP;
        end
      end
      ST_LOCK: begin
        if (fb.workLast) begin
          stateNxt      = ST_IDLE;
          strb.setBlk   = (kindQ == LK_BLK);
          strb.setMst   = (kindQ == LK_MST);
          strb.clrLocks = (kindQ == LK_CLR);
        end else strb.decWork = 1'b1;
      end
      ST_ESUSP: begin
        if (accept) begin
          case (op)
            OP_RESUME: stateNxt = ST_ERASE;
            OP_PROG: begin
              if (fb.sameAsErase) strb.errProg = 1'b1;
              else if (fb.blkLocked) begin
                strb.errProg = 1'b1;
                strb.errLock = 1'b1;
              end else begin
                strb.loadWork   = 1'b1;
                strb.workIsProg = 1'b1;
                stateNxt        = ST_ESPROG;
              end
            end
            OP_CLR_STAT: strb.clrErr = 1'b1;
            default: ;
          endcase
        end
      end
      ST_ESPROG: begin
        if (fb.workLast) stateNxt = ST_ESUSP;
        else strb.decWork = 1'b1;
      end
      ST_PSUSP: begin
        if (accept) begin
          if (op == OP_RESUME) stateNxt = ST_PROG;
          else if (op == OP_CLR_STAT) strb.clrErr = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign readyFlag = !(stateQ inside {ST_ERASE, ST_PROG, ST_LOCK, ST_ESPROG});
  assign eraseSusp = (stateQ inside {ST_ESUSP, ST_ESPROG});
  assign progSusp  = (stateQ == ST_PSUSP);

  // A refused operation leaves the machine where it was
  assert_refuse_no_move_R6: assert property (@(posedge clk) disable iff (!pwrDnN)
    strb.errLock |=> (stateQ == $past(stateQ)));

  // Ready only drops right after a presented command
  assert_busy_needs_cmd_R3: assert property (@(posedge clk) disable iff (!pwrDnN)
    $fell(readyFlag) |-> $past(cmdValid));

  // Nothing moves before the wake delay is over
  assert_wake_ignore_R2: assert property (@(posedge clk) disable iff (!pwrDnN)
    (!fb.wakeDone && stateQ == ST_IDLE) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/fwc_datapath.sv
module fwc_datapath
  import fwc_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int ERASE_CYC  = 1000,
  parameter int PROG_CYC   = 12,
  parameter int LOCK_CYC   = 8,
  parameter int WAKE_CYC   = 16
)(
  input  logic                          clk,
  input  logic                          pwrDnN,
  input  logic [$clog2(NUM_BLOCKS)-1:0] cmdBlock,
  input  fwc_strobe_t                   strb,
  output fwc_fb_t                       fb,
  output logic [NUM_BLOCKS-1:0]         lockBits,
  output logic                          masterLock,
  output logic                          errErase,
  output logic                          errProg,
  output logic                          errLock
);

  localparam int BLK_W   = $clog2(NUM_BLOCKS);
  localparam int WORK_MX = (PROG_CYC > LOCK_CYC) ? PROG_CYC : LOCK_CYC;
  localparam int MAX_CYC = (ERASE_CYC > WORK_MX) ? ERASE_CYC : WORK_MX;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int WAKE_W  = $clog2(WAKE_CYC + 2);

  logic [CNT_W-1:0]      eraseCnt, workCnt;
  logic [BLK_W-1:0]      eraseBlk, workBlk;
  logic [WAKE_W-1:0]     wakeCnt;
  logic [NUM_BLOCKS-1:0] lockQ;
  logic                  masterQ = 1'b0;
  logic                  errEraseQ, errProgQ, errLockQ;

  always_ff @(posedge clk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      eraseCnt <= '0;
      workCnt  <= '0;
      eraseBlk <= '0;
      workBlk  <= '0;
      wakeCnt  <= WAKE_W'(WAKE_CYC);
    end else begin
      if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
      if (strb.loadErase) begin
        eraseCnt <= CNT_W'(ERASE_CYC);
        eraseBlk <= cmdBlock;
      end else if (strb.decErase) eraseCnt <= eraseCnt - 1'b1;
      if (strb.loadWork) begin
        workCnt <= strb.workIsProg ? CNT_W'(PROG_CYC) : CNT_W'(LOCK_CYC);
        workBlk <= cmdBlock;
      end else if (strb.decWork) workCnt <= workCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwrDnN) begin
    if (!pwrDnN) begin
      errEraseQ <= 1'b0;
      errProgQ  <= 1'b0;
      errLockQ  <= 1'b0;
    end else if (strb.clrErr) begin
      errEraseQ <= 1'b0;
      errProgQ  <= 1'b0;
      errLockQ  <= 1'b0;
    end else begin
      if (strb.errErase) errEraseQ <= 1'b1;
      if (strb.errProg)  errProgQ  <= 1'b1;
      if (strb.errLock)  errLockQ  <= 1'b1;
    end
  end

  // lock-bits survive power-down: no reset, power-on value only
  always_ff @(posedge clk) begin
    if (strb.setMst) masterQ <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gLock
    logic bitQ = 1'b0;
    always_ff @(posedge clk) begin
      if (strb.clrLocks) bitQ <= 1'b0;
      else if (strb.setBlk && workBlk == BLK_W'(b)) bitQ <= 1'b1;
    end
    assign lockQ[b] = bitQ;
  end

  assign fb.eraseLast   = (eraseCnt == CNT_W'(1));
  assign fb.workLast    = (workCnt == CNT_W'(1));
  assign fb.wakeDone    = (wakeCnt == '0);
  assign fb.blkLocked   = lockQ[cmdBlock];
  assign fb.sameAsErase = (cmdBlock == eraseBlk);
  assign fb.masterLock  = masterQ;

  assign lockBits   = lockQ;
  assign masterLock = masterQ;
  assign errErase   = errEraseQ;
  assign errProg    = errProgQ;
  assign errLock    = errLockQ;

  assert_lock_commit_only_R5: assert property (@(posedge clk) disable iff (!pwrDnN)
    !(strb.setBlk || strb.setMst || strb.clrLocks) |=> ($stable(lockQ) && $stable(masterQ)));

  assert_erase_cnt_live_R8: assert property (@(posedge clk) disable iff (!pwrDnN)
    strb.decErase |-> (eraseCnt > CNT_W'(1)));

  assert_work_cnt_live_R4: assert property (@(posedge clk) disable iff (!pwrDnN)
    strb.decWork |-> (workCnt > CNT_W'(1)));

endmodule

// File: rtl/flash_write_ctrl.sv
module flash_write_ctrl
  import fwc_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int ERASE_CYC  = 1000,
  parameter int PROG_CYC   = 12,
  parameter int LOCK_CYC   = 8,
  parameter int WAKE_CYC   = 16
)(
  input  logic                          clk,
  input  logic                          pwrDnN,
  input  logic                          cmdValid,
  input  logic [3:0]                    cmdOp,
  input  logic [$clog2(NUM_BLOCKS)-1:0] cmdBlock,
  output logic                          readyOut,
  output logic [7:0]                    status,
  output logic [NUM_BLOCKS-1:0]         lockBits,
  output logic                          masterLock
);

  fwc_strobe_t strb;
  fwc_fb_t     fb;
  logic        readyFlag, eraseSusp, progSusp;
  logic        errErase, errProg, errLock;

  fwc_control uCtrl (
    .clk       (clk),
    .pwrDnN    (pwrDnN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .fb        (fb),
    .strb      (strb),
    .readyFlag (readyFlag),
    .eraseSusp (eraseSusp),
    .progSusp  (progSusp)
  );

  fwc_datapath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .ERASE_CYC  (ERASE_CYC),
    .PROG_CYC   (PROG_CYC),
    .LOCK_CYC   (LOCK_CYC),
    .WAKE_CYC   (WAKE_CYC)
  ) uData (
    .clk        (clk),
    .pwrDnN     (pwrDnN),
    .cmdBlock   (cmdBlock),
    .strb       (strb),
    .fb         (fb),
    .lockBits   (lockBits),
    .masterLock (masterLock),
    .errErase   (errErase),
    .errProg    (errProg),
    .errLock    (errLock)
  );

  assign readyOut = readyFlag;
  assign status   = {readyFlag, eraseSusp, errErase, errProg, errLock, progSusp, 2'b00};

endmodule

// File: tb/tb_flash_write_ctrl.sv
module tb_flash_write_ctrl;

  localparam int NB = 8, EC = 10, PC = 4, LC = 3, WC = 3;

  logic       clk = 1'b0;
  logic       pwrDnN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdOp = 4'd0;
  logic [2:0] cmdBlock = 3'd0;
  logic       readyOut, masterLock;
  logic [7:0] status;
  logic [7:0] lockBits;

  flash_write_ctrl #(.NUM_BLOCKS(NB), .ERASE_CYC(EC), .PROG_CYC(PC),
                     .LOCK_CYC(LC), .WAKE_CYC(WC)) dut (
    .clk(clk), .pwrDnN(pwrDnN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .readyOut(readyOut), .status(status),
    .lockBits(lockBits), .masterLock(masterLock));

  always #4 clk = ~clk;

  typedef struct {
    int       at;
    bit       rdy;
    bit [7:0] st;
    bit [7:0] lk;
    bit       mst;
    string    tag;
  } item_t;

  item_t    sb[$];
  int       cyc = 0;
  int       checks = 0, errors = 0;
  bit       finished = 1'b0;
  bit [7:0] expLk = 8'h00;
  bit       expMst = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare expected items due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.at != cyc || readyOut !== it.rdy || status !== it.st ||
          lockBits !== it.lk || masterLock !== it.mst) begin
        errors++;
        $display("FAIL %s cyc %0d: rdy=%b st=%h lk=%h mst=%b expected cyc %0d rdy=%b st=%h lk=%h mst=%b",
                 it.tag, cyc, readyOut, status, lockBits, masterLock,
                 it.at, it.rdy, it.st, it.lk, it.mst);
      end
    end
  end

  task automatic expectAt(int at, bit rdy, bit [7:0] st, string tag);
    item_t it;
    it.at = at; it.rdy = rdy; it.st = st; it.lk = expLk; it.mst = expMst; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(bit [3:0] op, bit [2:0] blk);
    cmdValid = 1'b1; cmdOp = op; cmdBlock = blk;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 4'd0;
  endtask

  task automatic runOp(bit [3:0] op, bit [2:0] blk, int n, bit [7:0] stBusy,
                       bit [7:0] stAfter, bit [7:0] newLk, bit newMst, string tag);
    int c = cyc;
    expectAt(c + 1, 1'b0, stBusy, tag);
    expectAt(c + n, 1'b0, stBusy, tag);
    expLk = newLk; expMst = newMst;
    expectAt(c + n + 1, 1'b1, stAfter, tag);
    issue(op, blk);
    tick(n);
  endtask

  task automatic instant(bit [3:0] op, bit [2:0] blk, bit [7:0] st, string tag);
    expectAt(cyc + 1, 1'b1, st, tag);
    issue(op, blk);
    tick(1);
  endtask

  initial begin
    int c;
    @(negedge clk);
    // R1: power-down holds ready, clears status, ignores commands
    c = cyc;
    expectAt(c + 1, 1'b1, 8'h80, "R1 reset");
    expectAt(c + 2, 1'b1, 8'h80, "R1 reset");
    cmdValid = 1'b1; cmdOp = 4'd1; cmdBlock = 3'd0;
    tick(2);
    cmdValid = 1'b0;
    tick(1);

    // R2: wake delay, then accepted on the first eligible edge (R4 program length)
    c = cyc;
    expectAt(c + 1, 1'b1, 8'h80, "R2 wake");
    expectAt(c + 3, 1'b1, 8'h80, "R2 wake");
    expectAt(c + 4, 1'b0, 8'h00, "R2 first accept");
    expectAt(c + 7, 1'b0, 8'h00, "R4 program busy");
    expectAt(c + 8, 1'b1, 8'h80, "R4 program done");
    pwrDnN = 1'b1;
    cmdValid = 1'b1; cmdOp = 4'd2; cmdBlock = 3'd1;
    tick(4);
    cmdValid = 1'b0;
    tick(4);

    // R3: erase length
    runOp(4'd1, 3'd2, EC, 8'h00, 8'h80, 8'h00, 1'b0, "R3 erase");

    // R13: commands during busy ignored
    c = cyc;
    expectAt(c + 1, 1'b0, 8'h00, "R13 busy");
    expectAt(c + 10, 1'b0, 8'h00, "R13 busy");
    expectAt(c + 11, 1'b1, 8'h80, "R13 no extra op");
    expectAt(c + 12, 1'b1, 8'h80, "R13 no extra op");
    issue(4'd1, 3'd2);
    issue(4'd2, 3'd3);
    tick(10);

    // R5: set block lock-bit on block 5
    runOp(4'd5, 3'd5, LC, 8'h00, 8'h80, 8'h20, 1'b0, "R5 set block lock");

    // R6: refused erase/program on locked block
    instant(4'd1, 3'd5, 8'hA8, "R6 erase locked");
    instant(4'd2, 3'd5, 8'hB8, "R6 program locked");

    // R11: clear status
    instant(4'd8, 3'd0, 8'h80, "R11 clear");

    // R5: set master lock-bit
    runOp(4'd6, 3'd0, LC, 8'h00, 8'h80, 8'h20, 1'b1, "R5 set master");

    // R7: lock configurations refused under master lock
    instant(4'd7, 3'd0, 8'h98, "R7 clear-all refused");
    instant(4'd5, 3'd0, 8'h98, "R7 set-block refused");
    instant(4'd8, 3'd0, 8'h80, "R11 clear");
    runOp(4'd1, 3'd2, EC, 8'h00, 8'h80, 8'h20, 1'b1, "R7 erase under master");

    // R8: erase suspend after 4 busy cycles
    c = cyc;
    expectAt(c + 1, 1'b0, 8'h00, "R8 erase busy");
    expectAt(c + 4, 1'b0, 8'h00, "R8 erase busy");
    expectAt(c + 5, 1'b1, 8'hC0, "R8 suspended");
    issue(4'd1, 3'd1);
    tick(3);
    issue(4'd3, 3'd0);
    // R10: program to suspended block refused, other block runs
    instant(4'd2, 3'd1, 8'hD0, "R10 same block");
    instant(4'd8, 3'd0, 8'hC0, "R11 keeps suspend bit");
    runOp(4'd2, 3'd3, PC, 8'h40, 8'hC0, 8'h20, 1'b1, "R10 program in suspend");
    // R8: remaining 6 cycles after resume
    runOp(4'd4, 3'd0, EC - 4, 8'h00, 8'h80, 8'h20, 1'b1, "R8 resume");

    // R9: program suspend after 1 busy cycle
    c = cyc;
    expectAt(c + 1, 1'b0, 8'h00, "R9 program busy");
    expectAt(c + 2, 1'b1, 8'h84, "R9 suspended");
    issue(4'd2, 3'd4);
    issue(4'd3, 3'd0);
    runOp(4'd4, 3'd0, PC - 1, 8'h00, 8'h80, 8'h20, 1'b1, "R9 resume");

    // R1/R12: power-down mid erase, locks retained
    c = cyc;
    expectAt(c + 1, 1'b0, 8'h00, "R1 erase before power-down");
    expectAt(c + 2, 1'b1, 8'h80, "R1 aborted");
    issue(4'd1, 3'd2);
    pwrDnN = 1'b0;
    tick(2);
    pwrDnN = 1'b1;
    tick(WC);
    instant(4'd7, 3'd0, 8'h98, "R12 master retained");

    tick(2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all R): actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule